// File: doc/BRIEF.md
# Dual-Mode Display-ID Serial Memory

This block is a 128-byte serial memory slave, the kind a display panel uses to hand its identification data to a host. After reset it runs in a broadcast mode. It needs no addressing. Each pulse on a separate video clock input moves one bit of the array onto the data line, so a host that can only toggle that clock can still read every byte in turn.

The first falling edge on the serial clock moves the block into an ordinary two-wire slave mode, and the block stays there until the next reset. In that mode it answers a fixed device-select code and acknowledges each byte. It supports addressed writes, random reads and sequential reads, and a write-allow pin gates every store into the array.

The data line is open-drain. The block never drives it high. It only asserts a pull-low enable, and the line is pulled up externally. The bus pins are sampled with a system clock, and all edge and condition detection works on the synchronized copies. The array is not cleared by reset, so it keeps its contents across reset the way a non-volatile part would.

Top module: `dispid_mem`

## Requirements
- R1: While `rst_n` is low, `sda_oe_o` stays 0, whatever happens on the serial clock, data and video clock pins.
- R2: After reset the block is in broadcast mode, starting at address 00h. Bit 7 of the current byte is on the line first. Each rising edge of `vclk_i`, taken while `scl_i` is high, moves to the next bit. The ninth pulse of every byte carries a released (high) don't-care bit.
- R3: In broadcast mode the address advances by one after every nine-pulse byte, and it wraps from 7Fh to 00h.
- R4: A falling edge on `scl_i` in broadcast mode switches the block to two-wire mode and releases the line. After that, `vclk_i` pulses have no effect, and the block stays in two-wire mode until reset.
- R5: A START is SDA falling while SCL is high. The select byte that follows is acknowledged (line low during the ninth clock) only when its upper seven bits are 1010000. Bit 0 is read (1) or write (0). Any other select is not acknowledged.
- R6: After a write select, the next byte is the word address, and its bit 7 is ignored. Each following data byte is acknowledged and stored at the current address, which then advances with wrap from 7Fh to 00h.
- R7: When `wr_allow_i` is 0, written data bytes are still acknowledged, but the array is left unchanged.
- R8: A repeated START with a read select returns the byte at the current address, MSB first. The address advances after every byte. Reading goes on while the master acknowledges, and ends when the master does not acknowledge.
- R9: A STOP (SDA rising while SCL is high) returns the slave to idle, and the array contents survive a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus pins |
| rst_n | input | 1 | Active-low asynchronous reset, stands in for power-on reset |
| scl_i | input | 1 | Serial clock from the bus master |
| sda_i | input | 1 | Level seen on the shared data line |
| sda_oe_o | output | 1 | Pull the data line low when 1 |
| vclk_i | input | 1 | Video clock that paces broadcast mode |
| wr_allow_i | input | 1 | Write gate in two-wire mode, 1 allows stores |

## Verification
The bench streams the whole array in broadcast mode plus one more byte. A counter that failed to wrap, or that lost a don't-care pulse, would then show a shifted pattern after 7Fh. It writes with the gate low and reads back, which catches a design that stores anyway or that withholds the acknowledge. It sends a select with a wrong address bit, which a loose comparator would acknowledge. It also pulses the video clock after the mode switch, so a design that fell back into broadcast would start pulling the line low again. A write that starts at 7Fh, and a read that runs past it, would land at 80h or return stale data if the address counter were not seven bits wide.

// File: rtl/dispid_pkg.sv
package dispid_pkg;

  typedef enum logic [3:0] {
    TW_IDLE,
    TW_DEV,
    TW_ACK_DEV,
    TW_WADDR,
    TW_ACK_ADDR,
    TW_WDATA,
    TW_ACK_DATA,
    TW_RDATA,
    TW_RACK
  } tw_state_e;

endpackage

// File: rtl/dispid_sync.sv
module dispid_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] q_prev
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= stage_q[STAGES-1];
  end

  assign q      = stage_q[STAGES-1];
  assign q_prev = prev_q;

endmodule

// File: rtl/dispid_bcast.sv
module dispid_bcast #(
  parameter int AW             = 7,
  parameter int DW             = 8,
  parameter int PULSES_PER_WORD = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          scl_hi,
  input  logic          vclk_rise,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] rd_addr,
  output logic          oe
);

  localparam int CW = $clog2(PULSES_PER_WORD);
  localparam int BW = $clog2(DW);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          adv;
  logic [BW-1:0] bit_ix;

  assign adv    = active & scl_hi & vclk_rise;
  assign bit_ix = BW'(DW-1) - cnt_q[BW-1:0];

  always_comb begin
    cnt_d  = cnt_q;
    addr_d = addr_q;
    if (adv) begin
      if (cnt_q == CW'(PULSES_PER_WORD-1)) begin
        cnt_d  = '0;
        addr_d = addr_q + 1'b1;
      end else begin
        cnt_d  = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      addr_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
    end
  end

  assign rd_addr = addr_q;
  assign oe      = active & (cnt_q < CW'(DW)) & ~rdata[bit_ix];

endmodule

// File: rtl/dispid_twi.sv
module dispid_twi
  import dispid_pkg::*;
#(
  parameter int             AW     = 7,
  parameter int             DW     = 8,
  parameter logic [DW-2:0]  DEV_ID = 7'b1010000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_in,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic          wr_allow,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] rd_addr,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [DW-1:0] wdata,
  output logic          oe
);

  localparam int CW = $clog2(DW + 1);
  localparam int BW = $clog2(DW);

  tw_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] sh_q, sh_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic          rw_q, rw_d;
  logic          mack_q, mack_d;
  logic          oe_q, oe_d;
  logic          we_q, we_d;
  logic [AW-1:0] wa_q, wa_d;
  logic [DW-1:0] wd_q, wd_d;
  logic [BW-1:0] next_ix;

  assign next_ix = BW'(DW-2) - cnt_q[BW-1:0];

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    ptr_d  = ptr_q;
    rw_d   = rw_q;
    mack_d = mack_q;
    oe_d   = oe_q;
    we_d   = 1'b0;
    wa_d   = wa_q;
    wd_d   = wd_q;
    if (!active) begin
      st_d = TW_IDLE;
      oe_d = 1'b0;
    end else if (start_ev) begin
      st_d  = TW_DEV;
      cnt_d = '0;
      oe_d  = 1'b0;
    end else if (stop_ev) begin
      st_d = TW_IDLE;
      oe_d = 1'b0;
    end else begin
      case (st_q)
        TW_DEV, TW_WADDR, TW_WDATA: begin
          if (scl_rise && cnt_q < CW'(DW)) begin
            sh_d  = {sh_q[DW-2:0], sda_in};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CW'(DW)) begin
            if (st_q == TW_DEV) begin
              if (sh_q[DW-1:1] == DEV_ID) begin
                rw_d = sh_q[0];
                oe_d = 1'b1;
                st_d = TW_ACK_DEV;
              end else begin
                st_d = TW_IDLE;
              end
            end else if (st_q == TW_WADDR) begin
              ptr_d = sh_q[AW-1:0];
              oe_d  = 1'b1;
              st_d  = TW_ACK_ADDR;
            end else begin
              we_d  = wr_allow;
              wa_d  = ptr_q;
              wd_d  = sh_q;
              ptr_d = ptr_q + 1'b1;
              oe_d  = 1'b1;
              st_d  = TW_ACK_DATA;
            end
          end
        end
        TW_ACK_DEV: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rw_q) begin
              st_d = TW_RDATA;
              oe_d = ~rdata[DW-1];
            end else begin
              st_d = TW_WADDR;
              oe_d = 1'b0;
            end
          end
        end
        TW_ACK_ADDR, TW_ACK_DATA: begin
          if (scl_fall) begin
            cnt_d = '0;
            oe_d  = 1'b0;
            st_d  = TW_WDATA;
          end
        end
        TW_RDATA: begin
          if (scl_fall) begin
            if (cnt_q == CW'(DW-1)) begin
              st_d  = TW_RACK;
              oe_d  = 1'b0;
              ptr_d = ptr_q + 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
              oe_d  = ~rdata[next_ix];
            end
          end
        end
        TW_RACK: begin
          if (scl_rise) begin
            mack_d = ~sda_in;
          end else if (scl_fall) begin
            if (mack_q) begin
              st_d  = TW_RDATA;
              cnt_d = '0;
              oe_d  = ~rdata[DW-1];
            end else begin
              st_d = TW_IDLE;
            end
          end
        end
        default: begin
          st_d = TW_IDLE;
          oe_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TW_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      ptr_q  <= '0;
      rw_q   <= 1'b0;
      mack_q <= 1'b0;
      oe_q   <= 1'b0;
      we_q   <= 1'b0;
      wa_q   <= '0;
      wd_q   <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      ptr_q  <= ptr_d;
      rw_q   <= rw_d;
      mack_q <= mack_d;
      oe_q   <= oe_d;
      we_q   <= we_d;
      wa_q   <= wa_d;
      wd_q   <= wd_d;
    end
  end

  assign rd_addr = ptr_q;
  assign we      = we_q;
  assign waddr   = wa_q;
  assign wdata   = wd_q;
  assign oe      = oe_q;

endmodule

// File: rtl/dispid_mem.sv
module dispid_mem
  import dispid_pkg::*;
#(
  parameter int            AW     = 7,
  parameter int            DW     = 8,
  parameter logic [DW-2:0] DEV_ID = 7'b1010000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o,
  input  logic vclk_i,
  input  logic wr_allow_i
);

  localparam int WORDS   = 1 << AW;
  localparam int IX_SCL  = 0;
  localparam int IX_SDA  = 1;
  localparam int IX_VCLK = 2;

  logic [2:0]    sy_q, sy_p;
  logic          scl_rise, scl_fall, sda_rise, sda_fall, vclk_rise;
  logic          start_ev, stop_ev;
  logic          bidi_q, bidi_d;
  logic [AW-1:0] bc_addr, tw_addr, rd_addr;
  logic          bc_oe, tw_oe;
  logic          tw_we;
  logic [AW-1:0] tw_waddr;
  logic [DW-1:0] tw_wdata;
  logic [DW-1:0] rdata;
  logic [DW-1:0] mem_q [WORDS];

  dispid_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b011)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d      ({vclk_i, sda_i, scl_i}),
    .q      (sy_q),
    .q_prev (sy_p)
  );

  assign scl_rise  =  sy_q[IX_SCL]  & ~sy_p[IX_SCL];
  assign scl_fall  = ~sy_q[IX_SCL]  &  sy_p[IX_SCL];
  assign sda_rise  =  sy_q[IX_SDA]  & ~sy_p[IX_SDA];
  assign sda_fall  = ~sy_q[IX_SDA]  &  sy_p[IX_SDA];
  assign vclk_rise =  sy_q[IX_VCLK] & ~sy_p[IX_VCLK];

  assign start_ev = bidi_q & sy_q[IX_SCL] & sda_fall;
  assign stop_ev  = bidi_q & sy_q[IX_SCL] & sda_rise;

  assign bidi_d = bidi_q | scl_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bidi_q <= 1'b0;
    else        bidi_q <= bidi_d;
  end

  dispid_bcast #(.AW(AW), .DW(DW), .PULSES_PER_WORD(DW + 1)) u_bcast (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (~bidi_q),
    .scl_hi    (sy_q[IX_SCL]),
    .vclk_rise (vclk_rise),
    .rdata     (rdata),
    .rd_addr   (bc_addr),
    .oe        (bc_oe)
  );

  dispid_twi #(.AW(AW), .DW(DW), .DEV_ID(DEV_ID)) u_twi (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (bidi_q),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_in   (sy_q[IX_SDA]),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .wr_allow (wr_allow_i),
    .rdata    (rdata),
    .rd_addr  (tw_addr),
    .we       (tw_we),
    .waddr    (tw_waddr),
    .wdata    (tw_wdata),
    .oe       (tw_oe)
  );

  // array model: deliberately not reset, contents persist like non-volatile cells
  always_ff @(posedge clk) begin
    if (tw_we) mem_q[tw_waddr] <= tw_wdata;
  end

  assign rd_addr  = bidi_q ? tw_addr : bc_addr;
  assign rdata    = mem_q[rd_addr];
  assign sda_oe_o = rst_n & (bidi_q ? tw_oe : bc_oe);

endmodule

// File: rtl/dispid_mem_chk.sv
module dispid_mem_chk (
  input logic clk,
  input logic rst_n,
  input logic sda_oe,
  input logic bidi,
  input logic scl_fall,
  input logic start_ev,
  input logic stop_ev,
  input logic mem_we
);

  // R1
  line_free_in_reset_chk: assert property (@(posedge clk) !rst_n |-> !sda_oe);

  // R4
  mode_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bidi |=> bidi);

  // R4
  mode_entry_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bidi) |-> $past(scl_fall));

  // R5
  line_moves_on_bus_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bidi && $past(bidi) && !$stable(sda_oe)) |-> $past(scl_fall || start_ev || stop_ev));

  // R6
  store_only_two_wire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> bidi);

  // R6
  store_after_clock_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(scl_fall));

endmodule

bind dispid_mem dispid_mem_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sda_oe   (sda_oe_o),
  .bidi     (bidi_q),
  .scl_fall (scl_fall),
  .start_ev (start_ev),
  .stop_ev  (stop_ev),
  .mem_we   (tw_we)
);

// File: tb/dispid_mem_test.sv
`timescale 1ns/1ps
module dispid_mem_test;

  localparam int GAP = 12;

  typedef struct {
    logic [7:0] val;
    string      req;
  } exp_t;

  logic clk;
  logic rst_n;
  logic scl;
  logic sda_m;
  logic vclk;
  logic wr_allow;
  logic sda_oe;
  wire  sda_line = ~sda_oe & sda_m;

  int total;
  int bad;
  logic [7:0] model [128];
  exp_t exp_q [$];
  logic [7:0] got_b;
  event got_ev;

  dispid_mem uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl),
    .sda_i      (sda_line),
    .sda_oe_o   (sda_oe),
    .vclk_i     (vclk),
    .wr_allow_i (wr_allow)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 29 + 7) ^ 8'h5C);
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic gap();
    repeat (GAP) @(negedge clk);
  endtask

  task automatic expect_byte(input logic [7:0] v, input string req);
    exp_t e;
    e.val = v;
    e.req = req;
    exp_q.push_back(e);
  endtask

  // monitor: pops the oldest expectation whenever a byte is captured
  always @(got_ev) begin
    exp_t e;
    if (exp_q.size() == 0) begin
      chk(1'b0, "scoreboard-empty", int'(got_b), 0);
    end else begin
      e = exp_q.pop_front();
      chk(got_b == e.val, e.req, int'(got_b), int'(e.val));
    end
  end

  task automatic bc_byte();
    logic [7:0] v;
    for (int b = 7; b >= 0; b--) begin
      v[b] = sda_line;
      vclk = 1'b1; gap();
      vclk = 1'b0; gap();
    end
    chk(sda_line == 1'b1, "R2 ninth pulse released", int'(sda_line), 1);
    vclk = 1'b1; gap();
    vclk = 1'b0; gap();
    got_b = v;
    ->got_ev;
  endtask

  task automatic start_c();
    sda_m = 1'b1; gap();
    scl   = 1'b1; gap();
    sda_m = 1'b0; gap();
    scl   = 1'b0; gap();
  endtask

  task automatic stop_c();
    sda_m = 1'b0; gap();
    scl   = 1'b1; gap();
    sda_m = 1'b1; gap();
  endtask

  task automatic wbyte(input logic [7:0] v, input logic exp_ack, input string req);
    logic ack;
    for (int b = 7; b >= 0; b--) begin
      sda_m = v[b]; gap();
      scl   = 1'b1; gap();
      scl   = 1'b0; gap();
    end
    sda_m = 1'b1; gap();
    scl   = 1'b1; gap();
    ack   = (sda_line == 1'b0);
    scl   = 1'b0; gap();
    chk(ack == exp_ack, req, int'(ack), int'(exp_ack));
  endtask

  task automatic rbyte(input logic give_ack);
    logic [7:0] v;
    sda_m = 1'b1;
    for (int b = 7; b >= 0; b--) begin
      gap();
      scl  = 1'b1; gap();
      v[b] = sda_line;
      scl  = 1'b0;
    end
    gap();
    sda_m = give_ack ? 1'b0 : 1'b1; gap();
    scl   = 1'b1; gap();
    scl   = 1'b0; gap();
    sda_m = 1'b1;
    got_b = v;
    ->got_ev;
  endtask

  task automatic rand_read(input logic [6:0] a, input int n, input string req);
    start_c();
    wbyte(8'hA0, 1'b1, "R5 write select ack");
    wbyte({1'b0, a}, 1'b1, "R6 word address ack");
    start_c();
    wbyte(8'hA1, 1'b1, "R8 read select ack");
    for (int i = 0; i < n; i++) begin
      expect_byte(model[7'(int'(a) + i)], req);
      rbyte(i != n - 1);
    end
    stop_c();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total    = 0;
    bad      = 0;
    rst_n    = 1'b0;
    scl      = 1'b1;
    sda_m    = 1'b1;
    vclk     = 1'b0;
    wr_allow = 1'b1;
    repeat (5) @(negedge clk);

    // R1: bus activity during reset
    for (int i = 0; i < 4; i++) begin
      scl = ~scl; vclk = ~vclk; sda_m = ~sda_m; gap();
      chk(sda_oe == 1'b0, "R1 line free in reset", int'(sda_oe), 0);
    end
    scl = 1'b1; sda_m = 1'b1; vclk = 1'b0; gap();
    rst_n = 1'b1; gap();

    // R4: switch to two-wire mode
    scl = 1'b0; gap();
    chk(sda_line == 1'b1, "R4 line released after switch", int'(sda_line), 1);

    // R6: fill whole array, address byte with bit 7 set (ignored)
    start_c();
    wbyte(8'hA0, 1'b1, "R5 write select ack");
    wbyte(8'h80, 1'b1, "R6 word address ack");
    for (int a = 0; a < 128; a++) begin
      wbyte(pat(a), 1'b1, "R6 data ack");
      model[a] = pat(a);
    end
    stop_c();

    // R8: random sequential read across 7Fh
    rand_read(7'h7E, 3, "R8 sequential read");

    // R7: writes with gate low are acked but do not store
    wr_allow = 1'b0;
    start_c();
    wbyte(8'hA0, 1'b1, "R7 select ack");
    wbyte(8'h10, 1'b1, "R7 address ack");
    wbyte(8'h00, 1'b1, "R7 data still acked");
    wbyte(8'hFF, 1'b1, "R7 data still acked");
    stop_c();
    wr_allow = 1'b1;
    rand_read(7'h10, 2, "R7 array unchanged");

    // R5: wrong device select not acknowledged
    start_c();
    wbyte(8'hA2, 1'b0, "R5 wrong select no ack");
    stop_c();
    start_c();
    wbyte(8'h20, 1'b0, "R5 wrong select no ack");
    stop_c();

    // R6: write wraps at 7Fh
    start_c();
    wbyte(8'hA0, 1'b1, "R6 select ack");
    wbyte(8'h7F, 1'b1, "R6 address ack");
    wbyte(8'h5A, 1'b1, "R6 data ack");
    wbyte(8'hC3, 1'b1, "R6 data ack");
    stop_c();
    model[127] = 8'h5A;
    model[0]   = 8'hC3;
    rand_read(7'h7F, 2, "R6 write wrap readback");

    // R9: reset keeps contents; back in broadcast mode
    rst_n = 1'b0; gap();
    chk(sda_oe == 1'b0, "R1 line free in reset", int'(sda_oe), 0);
    scl = 1'b1; sda_m = 1'b1; gap();
    rst_n = 1'b1; gap();

    // R2 / R3 / R9: stream full array plus one to see the wrap
    for (int i = 0; i < 129; i++) begin
      expect_byte(model[i % 128], (i == 128) ? "R3 broadcast wrap" : "R9 retained broadcast R2");
      bc_byte();
    end

    // R4: leave broadcast, video clock no longer drives the line
    scl = 1'b0; gap();
    for (int i = 0; i < 9; i++) begin
      vclk = 1'b1; gap();
      chk(sda_line == 1'b1, "R4 video clock ignored", int'(sda_line), 1);
      vclk = 1'b0; gap();
    end
    scl = 1'b1; gap();
    scl = 1'b0; gap();
    scl = 1'b1; gap();
    rand_read(7'h05, 1, "R4 two-wire persists");

    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule